// File: doc/BRIEF.md
# Complement-Retriggered Watchdog Timer

This block supervises software with an 8-bit down-counting watchdog that sits behind a single write/read register. The watchdog is dormant after a system reset. The first nonzero value software writes becomes the timeout, measured in ticks of an external prescaled timebase, and that write starts the watchdog. From then on the count is refreshed only by a two-write handshake. Software writes any value and then writes the exact bitwise inverse of that value. A lone write, or a random store to the register, does not rearm the timer.

When the count runs out, or the second write of a handshake is not the inverse of the first, the block raises a one-clock reset request toward the system reset logic. The same event sets a sticky cause flag. This flag is held on a separate power-on reset, so it survives the system reset that the request triggers. Software reads the flag back in bit 0 to learn why the chip restarted, and any write to the register clears it. After a system reset the stored timeout returns to all ones and the watchdog is dormant again.

Top module: `cpl_watchdog`

## Requirements
- R1: After reset, `rd_data` reads 8'hFE and the watchdog is inactive. In the inactive state, ticks never raise `wdt_rst`.
- R2: While inactive, a write of a nonzero value stores it as the timeout and activates the watchdog. `rd_data[7:1]` then shows bits 7:1 of the stored timeout.
- R3: While inactive, a write of 0 is ignored. The watchdog stays inactive, no number of ticks raises `wdt_rst`, and `rd_data` keeps reading 8'hFE.
- R4: Take an active watchdog with timeout N (1 to 255) and no completed handshake. `wdt_rst` is high for one clock, in the cycle after the edge that samples the N-th tick.
- R5: Two consecutive writes, where the second equals the bitwise complement of the first, reload the count with the stored timeout. The first value does not need to equal the timeout.
- R6: If the second write of a handshake is not the complement of the first, `wdt_rst` goes high in the cycle after that write.
- R7: The edge that raises `wdt_rst` also sets the cause flag in `rd_data[0]`. The flag survives `rst_n` and is cleared only by `por_n` or by a write.
- R8: Any write clears the cause flag, including an ignored write of 0. If a reset request is raised at the same edge as a write, the flag ends set.
- R9: Once active, no write can deactivate the watchdog, including a handshake of 0 then 8'hFF. Only `rst_n` returns it to the inactive state.
- R10: After a reset request, the count reloads with the stored timeout. The next write is then taken as the first write of a new handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert, released synchronously upstream |
| por_n | input | 1 | Power-on reset, active low; the only reset of the cause flag |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Timebase tick, one cycle wide |
| rd_data | output | 8 | Bits 7:1: stored timeout bits 7:1; bit 0: watchdog cause flag |
| wdt_rst | output | 1 | Reset request, one clock wide |

## Verification
The bench builds the block with the default 8-bit width, so every register value, complement and timeout is legal as written. Short timeouts of 3 and 5 ticks reach the expiry edge within a few cycles. This puts in reach the coincidences of an expiry with a handshake write, a mismatch, and a reload. The largest timeout of 255 is also exercised in full to reach the top end of the count. Three hundred ticks are also applied while the watchdog is still dormant after an ignored zero write.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WAIT_A = 2'd1,
    ST_WAIT_B = 2'd2
  } seq_st_e;

endpackage

// File: rtl/cwd_seq.sv
module cwd_seq
  import cwd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         expire,
  output logic         active,
  output logic [W-1:0] timeout,
  output logic         load,
  output logic         reload,
  output logic         mismatch
);

  localparam logic [W-1:0] ZERO = '0;

  seq_st_e      st_q, st_d;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] to_q, to_d;
  logic         pend_en, to_en;

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    to_d     = to_q;
    pend_en  = 1'b0;
    to_en    = 1'b0;
    load     = 1'b0;
    reload   = 1'b0;
    mismatch = 1'b0;
    case (st_q)
      ST_OFF: begin
        if (wr_en && (wr_data != ZERO)) begin
          load  = 1'b1;
          to_en = 1'b1;
          to_d  = wr_data;
          st_d  = ST_WAIT_A;
        end
      end
      ST_WAIT_A: begin
        if (wr_en) begin
          pend_en = 1'b1;
          pend_d  = wr_data;
          st_d    = ST_WAIT_B;
        end
      end
      ST_WAIT_B: begin
        if (wr_en) begin
          if (wr_data == ~pend_q) reload   = 1'b1;
          else                    mismatch = 1'b1;
          st_d = ST_WAIT_A;
        end
      end
      default: st_d = ST_OFF;
    endcase
    if (expire) begin
      st_d    = ST_WAIT_A;
      pend_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      pend_q <= '0;
      to_q   <= '1;
    end else begin
      st_q <= st_d;
      if (pend_en) pend_q <= pend_d;
      if (to_en)   to_q   <= to_d;
    end
  end

  assign active  = (st_q != ST_OFF);
  assign timeout = to_q;

endmodule

// File: rtl/cwd_count.sv
module cwd_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         restart,
  input  logic [W-1:0] timeout,
  input  logic         tick,
  output logic         expire
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (restart) begin
      cnt_d = timeout;
    end else if (active && tick) begin
      if (cnt_q == ONE) begin
        expire = 1'b1;
        cnt_d  = timeout;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cwd_flag.sv
module cwd_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

endmodule

// File: rtl/cpl_watchdog.sv
module cpl_watchdog #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         por_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic [W-1:0] rd_data,
  output logic         wdt_rst
);

  logic         active;
  logic [W-1:0] timeout;
  logic         load, reload, mismatch, expire;
  logic         fire, cause;
  logic         req_q, req_d;

  cwd_seq #(.W(W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .expire   (expire),
    .active   (active),
    .timeout  (timeout),
    .load     (load),
    .reload   (reload),
    .mismatch (mismatch)
  );

  cwd_count #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .load     (load),
    .load_val (wr_data),
    .restart  (reload | mismatch),
    .timeout  (timeout),
    .tick     (tick),
    .expire   (expire)
  );

  assign fire = expire | mismatch;

  cwd_flag u_flag (
    .clk   (clk),
    .por_n (por_n),
    .set   (fire),
    .clr   (wr_en),
    .flag  (cause)
  );

  always_comb req_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign wdt_rst = req_q;
  assign rd_data = {timeout[W-1:1], cause};

endmodule

// File: rtl/cpl_watchdog_chk.sv
module cpl_watchdog_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         por_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic         wdt_rst,
  input logic         active,
  input logic [W-1:0] timeout
);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= por_n;
  end

  // R1: a dormant watchdog never requests reset
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !active |-> !wdt_rst);

  // R3: a zero activating write leaves the watchdog dormant
  a_r3_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!active && wr_en && (wr_data == '0)) |=> !active);

  // R9: activation is permanent until system reset
  a_r9_stays_active: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    active |=> active);

  // R2: an active watchdog always holds a legal timeout
  a_r2_timeout_legal: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    active |-> (timeout != '0));

  // R7: every reset request is recorded in the cause flag
  a_r7_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    wdt_rst |-> rd_data[0]);

  // R8: a write clears the flag unless a request fired at that edge
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (seen_q && $past(wr_en) && !wdt_rst) |-> !rd_data[0]);

endmodule

bind cpl_watchdog cpl_watchdog_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .por_n   (por_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .wdt_rst (wdt_rst),
  .active  (active),
  .timeout (timeout)
);

// File: tb/sim_cpl_watchdog.sv
`timescale 1ns/1ps
module sim_cpl_watchdog;

  logic       clk = 1'b0;
  logic       rst_n, por_n, wr_en, tick;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       wdt_rst;
  int         errors = 0;
  int         checks = 0;

  always #2 clk = ~clk;

  cpl_watchdog #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
    .wr_data(wr_data), .tick(tick), .rd_data(rd_data), .wdt_rst(wdt_rst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic full_reset();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0; wr_data = '0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // n back-to-back ticks; request expected only after the last one when fire_last
  task automatic ticks(input int n, input logic fire_last, input string req);
    logic bad_act, bad_exp, bad;
    bad = 1'b0; bad_act = 1'b0; bad_exp = 1'b0;
    @(negedge clk); tick = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == n) tick = 1'b0;
      if (!bad && (wdt_rst !== (fire_last && (k == n)))) begin
        bad = 1'b1; bad_act = wdt_rst; bad_exp = fire_last && (k == n);
      end
    end
    if (bad) chk(req, {7'd0, bad_act}, {7'd0, bad_exp});
    else     chk(req, {7'd0, wdt_rst}, {7'd0, fire_last});
  endtask

  task automatic idle_low(input string req);
    @(negedge clk);
    chk(req, {7'd0, wdt_rst}, 8'd0);
  endtask

  task automatic t_reset();
    full_reset();
    chk("R1 reset read", rd_data, 8'hFE);
    chk("R1 reset req", {7'd0, wdt_rst}, 8'd0);
    ticks(10, 1'b0, "R1 dormant ticks");
  endtask

  task automatic t_zero_first();
    wr(8'h00);
    chk("R3 zero read", rd_data, 8'hFE);
    ticks(300, 1'b0, "R3 zero dormant");
  endtask

  task automatic t_activate_expire();
    wr(8'h03);
    chk("R2 activate read", rd_data, 8'h02);
    ticks(3, 1'b1, "R4 expiry at tick 3");
    chk("R7 flag on expiry", rd_data, 8'h03);
    idle_low("R4 one clock pulse");
  endtask

  task automatic t_sysreset_keeps_flag();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R7 flag kept over rst_n", rd_data, 8'hFF);
    chk("R7 req low after rst_n", {7'd0, wdt_rst}, 8'd0);
  endtask

  task automatic t_write_clears();
    wr(8'h05);
    chk("R8 write clears flag", rd_data, 8'h04);
  endtask

  task automatic t_pair();
    ticks(4, 1'b0, "R5 before pair");
    wr(8'h3C);
    wr(8'hC3);
    chk("R5 pair no req", {7'd0, wdt_rst}, 8'd0);
    ticks(4, 1'b0, "R5 reloaded count");
    ticks(1, 1'b1, "R5 expiry after reload");
    idle_low("R5 pulse end");
  endtask

  task automatic t_mismatch();
    wr(8'h11);
    chk("R8 first write clears", rd_data, 8'h04);
    wr(8'h22);
    chk("R6 mismatch req", {7'd0, wdt_rst}, 8'd1);
    chk("R7 mismatch flag", rd_data, 8'h05);
    idle_low("R6 pulse end");
  endtask

  task automatic t_after_fire();
    ticks(4, 1'b0, "R10 reload after fire");
    ticks(1, 1'b1, "R10 expiry after fire");
    idle_low("R10 pulse end");
    wr(8'h5A);
    wr(8'hA5);
    chk("R10 new pair accepted", {7'd0, wdt_rst}, 8'd0);
  endtask

  task automatic t_zero_pair();
    wr(8'h00);
    wr(8'hFF);
    chk("R9 zero pair no req", {7'd0, wdt_rst}, 8'd0);
    ticks(4, 1'b0, "R9 still counting");
    ticks(1, 1'b1, "R9 still active");
    idle_low("R9 pulse end");
  endtask

  task automatic t_coincide();
    ticks(4, 1'b0, "R8 lead-in");
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h10; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    chk("R8 coincident req", {7'd0, wdt_rst}, 8'd1);
    chk("R8 coincident flag set", rd_data, 8'h05);
    idle_low("R8 pulse end");
  endtask

  task automatic t_max();
    full_reset();
    wr(8'hFF);
    chk("R2 max activate", rd_data, 8'hFE);
    ticks(254, 1'b0, "R4 max lead");
    ticks(1, 1'b1, "R4 max expiry");
    idle_low("R4 max pulse end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0; wr_en = 1'b0; tick = 1'b0; wr_data = '0;
    t_reset();
    t_zero_first();
    t_activate_expire();
    t_sysreset_keeps_flag();
    t_write_clears();
    t_pair();
    t_mismatch();
    t_after_fire();
    t_zero_pair();
    t_coincide();
    t_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule